// File: doc/BRIEF.md
# Interrupt Mask and Status Gate

This block gathers a set of level-sensitive device request lines into a small bank of byte-wide I/O registers that sit at consecutive addresses on a simple byte bus. The request lines are first passed through a synchronizer. Software reading any register in the bank sees the live, unmasked request levels of the eight lines packed into that byte. Writing the same address loads a separate, write-only mask byte. A mask bit of 1 blocks its line, and a 0 lets it through.

One combined interrupt output goes to the processor. It is high whenever at least one synchronized request is active and its mask bit is clear. Line n lives in register n/8, at bit n%8. With the default of 19 lines, line 4 carries the request that cascades from the legacy ISA interrupt controller. Bits above the last line in the top register are reserved.

Top module: `intr_gate_bank`

## Requirements
- R1: After reset every mask bit is 1, so `irq_out` stays low whatever the request lines do until software clears a mask bit.
- R2: A read with `bus_rd` high at address BASE_ADDR+k returns the synchronized request levels of lines 8k to 8k+7, whatever the mask holds. The mask has no read path.
- R3: A write with `bus_wr` high at address BASE_ADDR+k loads mask byte k at the next clock edge. The other mask bytes are left unchanged.
- R4: A mask bit of 1 disables its line and a 0 enables it. `irq_out` is high exactly when some line is both active and unmasked, and it follows mask writes from the cycle after the write edge.
- R5: Reserved bits (bits 3 to 7 of the register at BASE_ADDR+2 with the defaults) read as 0. Writes to them have no effect on `irq_out`.
- R6: A change on `req_in` shows up in read data and in `irq_out` after exactly SYNC_STAGES rising clock edges (2 by default).
- R7: Reads at addresses outside BASE_ADDR to BASE_ADDR+NUM_REGS-1 return 0. Writes there change no mask bit.
- R8: Line n is reported at register n/8, bit n%8 (bit 0 is the least significant bit), and the same bit position of the mask byte gates it.
- R9: While `bus_rd` is low, `bus_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (12) | Byte address on the I/O bus |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | BYTE_W (8) | Write data, loaded into a mask byte |
| bus_rdata | output | BYTE_W (8) | Read data: raw request levels of the addressed byte |
| req_in | input | NUM_LINES (19) | Level-sensitive request lines, asynchronous |
| irq_out | output | 1 | Combined request to the processor |

## Verification
The bound checker verifies the following on every cycle:
- every mask bit is set on the first edge after reset;
- a write loads only the addressed mask byte, and the other bytes stay stable;
- reserved and idle read data are zero;
- `irq_out` stays low when all mask bits are set or no request is active.

Some behaviours can only be shown by the bench scenarios:
- the exact synchronizer latency;
- the bit placement of each of the 19 lines;
- that read data ignores the mask;
- that writes outside the window or to reserved bits leave the gating untouched.

The bench covers these with a per-line sweep and a pseudo-random sweep of mask and request patterns.

// File: rtl/intr_gate_pkg.sv
`timescale 1ns/1ps
package intr_gate_pkg;
   localparam int DEFAULT_BYTE_W = 8;

   // number of byte registers needed to hold a given number of lines
   function automatic int regs_needed(input int lines, input int width);
      return (lines + width - 1) / width;
   endfunction

   // number of real lines held in register k
   function automatic int lines_in_reg(input int lines, input int width, input int k);
      int rest;
      rest = lines - k * width;
      if (rest > width) return width;
      return rest;
   endfunction
endpackage

// File: rtl/intr_sync.sv
`timescale 1ns/1ps
module intr_sync #(
   parameter int WIDTH  = 1,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   if (STAGES == 0) begin : g_bypass
      assign q = d;
   end else begin : g_chain
      logic [STAGES-1:0][WIDTH-1:0] chain;
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         logic [WIDTH-1:0] flop_q;
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) flop_q <= '0;
               else        flop_q <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) flop_q <= '0;
               else        flop_q <= chain[s-1];
            end
         end
         assign chain[s] = flop_q;
      end
      assign q = chain[STAGES-1];
   end
endmodule

// File: rtl/intr_addr_decode.sv
`timescale 1ns/1ps
module intr_addr_decode #(
   parameter int ADDR_W    = 12,
   parameter int BASE_ADDR = 'h804,
   parameter int NUM_REGS  = 3
) (
   input  logic [ADDR_W-1:0]   addr,
   output logic [NUM_REGS-1:0] sel
);
   for (genvar k = 0; k < NUM_REGS; k++) begin : g_sel
      localparam logic [ADDR_W-1:0] MATCH = ADDR_W'(BASE_ADDR + k);
      assign sel[k] = (addr == MATCH);
   end
endmodule

// File: rtl/intr_mask_bank.sv
`timescale 1ns/1ps
module intr_mask_bank
   import intr_gate_pkg::*;
#(
   parameter int NUM_LINES = 19,
   parameter int BYTE_W    = 8,
   parameter int NUM_REGS  = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [NUM_REGS-1:0]  sel,
   input  logic [BYTE_W-1:0]    wdata,
   output logic [NUM_LINES-1:0] mask_q
);
   for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
      localparam int LO  = k * BYTE_W;
      localparam int CNT = lines_in_reg(NUM_LINES, BYTE_W, k);
      logic [CNT-1:0] bits_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                bits_q <= '1;
         else if (wr_en && sel[k])  bits_q <= wdata[CNT-1:0];
      end
      assign mask_q[LO +: CNT] = bits_q;
   end
endmodule

// File: rtl/intr_status_mux.sv
`timescale 1ns/1ps
module intr_status_mux #(
   parameter int NUM_LINES = 19,
   parameter int BYTE_W    = 8,
   parameter int NUM_REGS  = 3
) (
   input  logic                 rd_en,
   input  logic [NUM_REGS-1:0]  sel,
   input  logic [NUM_LINES-1:0] status,
   output logic [BYTE_W-1:0]    rdata
);
   localparam int PAD_W = NUM_REGS * BYTE_W;
   logic [PAD_W-1:0] padded;

   always_comb begin
      padded = '0;
      padded[NUM_LINES-1:0] = status;
   end

   always_comb begin
      rdata = '0;
      for (int k = 0; k < NUM_REGS; k++) begin
         if (rd_en && sel[k]) rdata = rdata | padded[k*BYTE_W +: BYTE_W];
      end
   end
endmodule

// File: rtl/intr_gate_bank.sv
`timescale 1ns/1ps
module intr_gate_bank
   import intr_gate_pkg::*;
#(
   parameter int NUM_LINES   = 19,
   parameter int BYTE_W      = DEFAULT_BYTE_W,
   parameter int ADDR_W      = 12,
   parameter int BASE_ADDR   = 'h804,
   parameter int SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic                 bus_rd,
   input  logic                 bus_wr,
   input  logic [BYTE_W-1:0]    bus_wdata,
   output logic [BYTE_W-1:0]    bus_rdata,
   input  logic [NUM_LINES-1:0] req_in,
   output logic                 irq_out
);
   localparam int NUM_REGS = regs_needed(NUM_LINES, BYTE_W);

   // elaboration-time parameter checks
   if (NUM_LINES < 1) begin : g_bad_lines
      $error("intr_gate_bank: NUM_LINES must be at least 1");
   end
   if (BYTE_W < 1) begin : g_bad_width
      $error("intr_gate_bank: BYTE_W must be at least 1");
   end
   if (SYNC_STAGES < 0) begin : g_bad_sync
      $error("intr_gate_bank: SYNC_STAGES must not be negative");
   end
   if (BASE_ADDR < 0 || BASE_ADDR + NUM_REGS > (1 << ADDR_W)) begin : g_bad_base
      $error("intr_gate_bank: register window does not fit the address space");
   end

   logic [NUM_LINES-1:0] req_sync;
   logic [NUM_LINES-1:0] mask_q;
   logic [NUM_REGS-1:0]  reg_sel;

   intr_sync #(
      .WIDTH  (NUM_LINES),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (req_in),
      .q     (req_sync)
   );

   intr_addr_decode #(
      .ADDR_W    (ADDR_W),
      .BASE_ADDR (BASE_ADDR),
      .NUM_REGS  (NUM_REGS)
   ) u_decode (
      .addr (bus_addr),
      .sel  (reg_sel)
   );

   intr_mask_bank #(
      .NUM_LINES (NUM_LINES),
      .BYTE_W    (BYTE_W),
      .NUM_REGS  (NUM_REGS)
   ) u_mask (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (bus_wr),
      .sel    (reg_sel),
      .wdata  (bus_wdata),
      .mask_q (mask_q)
   );

   intr_status_mux #(
      .NUM_LINES (NUM_LINES),
      .BYTE_W    (BYTE_W),
      .NUM_REGS  (NUM_REGS)
   ) u_status (
      .rd_en  (bus_rd),
      .sel    (reg_sel),
      .status (req_sync),
      .rdata  (bus_rdata)
   );

   // a line reaches the processor only while its mask bit is clear
   assign irq_out = |(req_sync & ~mask_q);
endmodule

// File: rtl/intr_gate_checker.sv
`timescale 1ns/1ps
module intr_gate_checker
   import intr_gate_pkg::*;
#(
   parameter int NUM_LINES = 19,
   parameter int BYTE_W    = 8,
   parameter int ADDR_W    = 12,
   parameter int BASE_ADDR = 'h804
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [ADDR_W-1:0]    bus_addr,
   input logic                 bus_rd,
   input logic                 bus_wr,
   input logic [BYTE_W-1:0]    bus_wdata,
   input logic [BYTE_W-1:0]    bus_rdata,
   input logic                 irq_out,
   input logic [NUM_LINES-1:0] mask_q,
   input logic [NUM_LINES-1:0] req_sync
);
   localparam int NUM_REGS = regs_needed(NUM_LINES, BYTE_W);
   localparam int TOP_CNT  = lines_in_reg(NUM_LINES, BYTE_W, NUM_REGS - 1);

   assert_reset_mask_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (&mask_q));

   assert_all_masked_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (&mask_q) |-> !irq_out);

   assert_no_request_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (req_sync == '0) |-> !irq_out);

   assert_idle_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |-> (bus_rdata == '0));

   if (TOP_CNT < BYTE_W) begin : g_reserved
      localparam logic [ADDR_W-1:0] TOP_ADDR = ADDR_W'(BASE_ADDR + NUM_REGS - 1);
      assert_reserved_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_rd && bus_addr == TOP_ADDR) |-> (bus_rdata[BYTE_W-1:TOP_CNT] == '0));
   end

   for (genvar k = 0; k < NUM_REGS; k++) begin : g_byte
      localparam int LO  = k * BYTE_W;
      localparam int CNT = lines_in_reg(NUM_LINES, BYTE_W, k);
      localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(BASE_ADDR + k);

      assert_byte_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_wr && bus_addr == MY_ADDR) |=> (mask_q[LO +: CNT] == $past(bus_wdata[CNT-1:0])));

      assert_byte_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
         !(bus_wr && bus_addr == MY_ADDR) |=> $stable(mask_q[LO +: CNT]));
   end
endmodule

bind intr_gate_bank intr_gate_checker #(
   .NUM_LINES (NUM_LINES),
   .BYTE_W    (BYTE_W),
   .ADDR_W    (ADDR_W),
   .BASE_ADDR (BASE_ADDR)
) u_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_rd    (bus_rd),
   .bus_wr    (bus_wr),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .irq_out   (irq_out),
   .mask_q    (mask_q),
   .req_sync  (req_sync)
);

// File: tb/intr_gate_bank_test.sv
`timescale 1ns/1ps
module intr_gate_bank_test;
   localparam int LINES = 19;
   localparam int AW    = 12;
   localparam int BASE  = 'h804;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [AW-1:0]   addr = '0;
   logic            rd = 1'b0;
   logic            wr = 1'b0;
   logic [7:0]      wdata = '0;
   logic [7:0]      rdata;
   logic [LINES-1:0] req = '0;
   logic            irq;

   int checks = 0;
   int fails  = 0;
   logic [23:0]      mask_m = '1;
   logic [LINES-1:0] req_m  = '0;
   logic [31:0]      lfsr   = 32'h1D0F_5A3C;

   always #10 clk = ~clk;

   intr_gate_bank uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (addr),
      .bus_rd    (rd),
      .bus_wr    (wr),
      .bus_wdata (wdata),
      .bus_rdata (rdata),
      .req_in    (req),
      .irq_out   (irq)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic exp_irq();
      return |(req_m & ~mask_m[LINES-1:0]);
   endfunction

   function automatic logic [7:0] exp_byte(input int k);
      logic [23:0] p;
      p = 24'(req_m);
      return p[k*8 +: 8];
   endfunction

   task automatic do_write(input logic [AW-1:0] a, input logic [7:0] d);
      int k;
      @(negedge clk);
      addr = a; wdata = d; wr = 1'b1;
      @(negedge clk);
      wr = 1'b0;
      k = int'(a) - BASE;
      if (k >= 0 && k < 3) mask_m[k*8 +: 8] = d;
   endtask

   task automatic do_read(input logic [AW-1:0] a, output logic [7:0] d);
      @(negedge clk);
      addr = a; rd = 1'b1;
      #1 d = rdata;
      rd = 1'b0;
   endtask

   task automatic drive_req(input logic [LINES-1:0] v);
      @(negedge clk);
      req = v;
      @(posedge clk);
      @(posedge clk);
      @(negedge clk);
      req_m = v;
   endtask

   task automatic mask_all(input logic [7:0] d);
      do_write(AW'(BASE),     d);
      do_write(AW'(BASE + 1), d);
      do_write(AW'(BASE + 2), d);
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   initial begin
      #(20 * 150000);
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      logic [7:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: fully masked after reset, even with every line active
      drive_req('1);
      #1 check("R1 irq low after reset with all lines active", 32'(irq), 32'd0);
      // R2: reads show raw levels although everything is masked
      for (int k = 0; k < 3; k++) begin
         do_read(AW'(BASE + k), d);
         check($sformatf("R2 raw read byte %0d under full mask", k), 32'(d), 32'(exp_byte(k)));
      end
      // R9: no read strobe means zero data
      @(negedge clk); addr = AW'(BASE); #1;
      check("R9 idle bus reads zero", 32'(rdata), 32'd0);
      // R5: reserved bits of the top register read zero
      do_read(AW'(BASE + 2), d);
      check("R5 reserved bits read zero", 32'(d[7:3]), 32'd0);

      // R6: latency of the synchronizer is exactly two edges
      drive_req('0);
      @(negedge clk); req = 19'h000FF;
      do_read(AW'(BASE), d);
      check("R6 one edge later still old value", 32'(d), 32'h00);
      do_read(AW'(BASE), d);
      check("R6 two edges later new value", 32'(d), 32'hFF);
      req_m = 19'h000FF;

      // R8/R4: sweep every line through position, mask and gating
      for (int n = 0; n < LINES; n++) begin
         logic [LINES-1:0] one;
         logic [7:0] en;
         one = '0; one[n] = 1'b1;
         mask_all(8'hFF);
         en = 8'hFF; en[n % 8] = 1'b0;
         do_write(AW'(BASE + n / 8), en);
         drive_req(one);
         #1 check($sformatf("R4 line %0d unmasked raises irq", n), 32'(irq), 32'(exp_irq()));
         do_read(AW'(BASE + n / 8), d);
         check($sformatf("R8 line %0d bit position", n), 32'(d), 32'(1 << (n % 8)));
         drive_req(~one);
         #1 check($sformatf("R4 only masked lines active for %0d", n), 32'(irq), 32'd0);
         do_write(AW'(BASE + n / 8), 8'hFF);
         drive_req(one);
         #1 check($sformatf("R4 line %0d masked again", n), 32'(irq), 32'd0);
      end

      // R3: writing one byte leaves the others untouched
      mask_all(8'hFF);
      drive_req(19'h000FF);
      do_write(AW'(BASE + 1), 8'h00);
      #1 check("R3 byte1 write leaves byte0 masked", 32'(irq), 32'd0);
      do_write(AW'(BASE + 2), 8'h00);
      #1 check("R3 byte2 write leaves byte0 masked", 32'(irq), 32'd0);
      do_write(AW'(BASE), 8'hFE);
      #1 check("R3 byte0 write takes effect", 32'(irq), 32'd1);

      // R5: reserved-bit writes do not mask real lines
      mask_all(8'hFF);
      drive_req(19'h70000);
      do_write(AW'(BASE + 2), 8'hF8);
      #1 check("R5 reserved ones keep lines 16-18 enabled", 32'(irq), 32'd1);
      do_write(AW'(BASE + 2), 8'h07);
      #1 check("R5 lines 16-18 masked", 32'(irq), 32'd0);

      // R7: accesses outside the window
      mask_all(8'hFF);
      drive_req('1);
      do_write(AW'(BASE - 1), 8'h00);
      do_write(AW'(BASE + 3), 8'h00);
      #1 check("R7 out-of-window writes change no mask", 32'(irq), 32'd0);
      do_read(AW'(BASE + 3), d);
      check("R7 read above window is zero", 32'(d), 32'd0);
      do_read(AW'(BASE - 1), d);
      check("R7 read below window is zero", 32'(d), 32'd0);

      // R2/R4: pseudo-random sweep of masks and requests
      for (int i = 0; i < 64; i++) begin
         for (int k = 0; k < 3; k++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            do_write(AW'(BASE + k), lfsr[7:0] | lfsr[15:8]);
         end
         lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
         drive_req(lfsr[LINES-1:0] & lfsr[31:13]);
         #1 check($sformatf("R4 random pattern %0d irq", i), 32'(irq), 32'(exp_irq()));
         for (int k = 0; k < 3; k++) begin
            do_read(AW'(BASE + k), d);
            check($sformatf("R2 random pattern %0d byte %0d", i, k), 32'(d), 32'(exp_byte(k)));
         end
      end

      finish_run();
   end
endmodule